// File: doc/BRIEF.md
# Half-Duplex Transmit Status Tracker

This block follows one frame through a shared-medium MAC transmitter and builds the status word reported when the frame completes. The transmit engine drives per-cycle event strobes: frame begin, attempt start, successful end, collision, data underflow, and a bit-time tick. The carrier-sense level also comes in. From these the block counts collisions and decides whether to ask for another attempt or give up. It times each deferral period and watches the collision window of each attempt. It records carrier presence and underflow. It then packs everything into a single word.

The status word leaves on a valid/ready interface. Once `stat_valid` rises, the word is stable and `stat_valid` stays high until a cycle with `stat_ready` high. That cycle completes the transfer. While the word waits, every event strobe and `frame_start` is ignored, so back-pressure from the consumer never changes a reported result. An underflow abort parks the block in a suspended state, and it stays there until `resume` is pulsed.

Top module: `hdx_txstat_tracker`

## Requirements
- R1: Each collision that is neither late nor final increments a collision count (0 to MAX_COLL-1). One cycle later it produces a one-cycle `retry_req` pulse and returns to deferral. On a successful end the count is reported in status bits 6:3.
- R2: The collision that reaches MAX_COLL (default 16) on one frame aborts the frame and sets status bit 8. When bit 8 is set, bits 6:3 read zero.
- R3: With `cfg_retry_off` high, the first collision sets bit 8 and aborts the frame, with no `retry_req`.
- R4: A collision that arrives after SLOT_BITS ticks (default 512, a 64-byte window that includes preamble) of the current attempt sets bit 9 and aborts the frame. The window count restarts on every attempt.
- R5: An underflow in the same cycle as a collision takes precedence. Status bit 1 is set and bit 9 reads zero whenever bit 1 is set.
- R6: With `cfg_defer_chk` high, the tick numbered DEFER_LIMIT+1 (default 24288) within one deferral period aborts the frame with status bit 2. The period restarts on each attempt. With the check disabled, deferral has no limit.
- R7: An underflow while transmitting aborts the frame, sets bit 1, and sets `suspended`. It also gives one-cycle pulses on `irq_underflow` and `irq_tx` in the following cycle.
- R8: While `suspended` is high, `frame_start` and all event strobes are ignored. Only `resume` clears it.
- R9: Status bit 10 is set when an attempt ends in the transmit state without carrier sense having been high during that attempt. It is zero for a deferral abort.
- R10: Status bit 0 is set when carrier sense was high while deferring in half-duplex mode. It reads zero when `cfg_full_duplex` is high.
- R11: `frame_start` in idle clears all flags and counts. Status bits 7 and 11 and above are always zero.
- R12: While `stat_valid` is high and `stat_ready` is low, `stat_word` is stable and events are ignored. The cycle after the handshake, `stat_valid` is low.
- R13: After reset, `stat_valid`, `retry_req`, `irq_underflow`, `irq_tx` and `suspended` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_retry_off | input | 1 | Abort on the first collision |
| cfg_defer_chk | input | 1 | Enable the deferral time limit |
| cfg_full_duplex | input | 1 | Full-duplex mode; masks the deferred flag |
| frame_start | input | 1 | New frame begins (accepted only in idle) |
| tx_start | input | 1 | Deferral over, attempt begins transmitting |
| tx_end | input | 1 | Frame sent successfully |
| col | input | 1 | Collision detected on this attempt |
| underflow | input | 1 | Transmit data arrived late |
| crs | input | 1 | Carrier sense level |
| tick | input | 1 | One bit time elapsed |
| resume | input | 1 | Leave the suspended state |
| stat_ready | input | 1 | Consumer accepts the status word |
| stat_valid | output | 1 | Status word available |
| stat_word | output | STAT_W | Packed completion status |
| retry_req | output | 1 | One-cycle request for a new attempt |
| irq_underflow | output | 1 | One-cycle underflow indication |
| irq_tx | output | 1 | One-cycle transmit interrupt |
| suspended | output | 1 | Transmitter halted after underflow |

## Verification
The assertions check on every cycle the invariants that do not need a scenario. These are the bounds of the collision, window and deferral counters, the masking of the count when the excessive-collision bit is set and of the late bit when the underflow bit is set, stability of the word under back-pressure, single-cycle retry pulses, the coupling of the underflow interrupts with suspension, and that suspension persists until resume. Only the bench's sweeps can show the exact thresholds. These include the collision number that aborts, the tick on which a collision turns late or deferral times out, and whether the window and deferral timers restart on each attempt. The sweeps also show the arithmetic value of every packed word for each ending path.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_XMIT,
    ST_REPORT,
    ST_SUSP
  } tx_state_e;

  localparam int BIT_NC    = 10;
  localparam int BIT_LC    = 9;
  localparam int BIT_EC    = 8;
  localparam int BIT_CC_LO = 3;
  localparam int BIT_ED    = 2;
  localparam int BIT_UF    = 1;
  localparam int BIT_DB    = 0;

  typedef struct packed {
    logic nc;
    logic lc;
    logic ec;
    logic ed;
    logic uf;
    logic db;
  } tx_flags_t;
endpackage

// File: rtl/txstat_defer_timer.sv
module txstat_defer_timer #(
  parameter int DEFER_LIMIT = 24288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  input  logic enable,
  output logic expired
);
  localparam int DW = $clog2(DEFER_LIMIT + 1);

  logic [DW-1:0] cnt_q;
  logic          at_limit;

  assign at_limit = (cnt_q == DW'(DEFER_LIMIT));
  assign expired  = run && tick && enable && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run && tick && !at_limit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_DEFER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DW'(DEFER_LIMIT)); // R6
  AST_DEFER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt_q == '0); // R6
endmodule

// File: rtl/txstat_slot_window.sv
module txstat_slot_window #(
  parameter int SLOT_BITS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic late
);
  localparam int SW = $clog2(SLOT_BITS + 1);

  logic [SW-1:0] cnt_q;

  assign late = (cnt_q >= SW'(SLOT_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run && tick && !late) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SW'(SLOT_BITS)); // R4
endmodule

// File: rtl/txstat_coll_tracker.sv
module txstat_coll_tracker #(
  parameter int MAX_COLL = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       hit,
  input  logic       retry_off,
  output logic       final_hit,
  output logic [3:0] count
);
  logic [3:0] cnt_q;

  assign final_hit = hit && (retry_off || cnt_q == 4'(MAX_COLL - 1));
  assign count     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (hit && !final_hit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_COLL_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 4'(MAX_COLL - 1)); // R1
endmodule

// File: rtl/hdx_txstat_tracker.sv
module hdx_txstat_tracker #(
  parameter int SLOT_BITS   = 512,
  parameter int DEFER_LIMIT = 24288,
  parameter int MAX_COLL    = 16,
  parameter int STAT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_retry_off,
  input  logic              cfg_defer_chk,
  input  logic              cfg_full_duplex,
  input  logic              frame_start,
  input  logic              tx_start,
  input  logic              tx_end,
  input  logic              col,
  input  logic              underflow,
  input  logic              crs,
  input  logic              tick,
  input  logic              resume,
  input  logic              stat_ready,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat_word,
  output logic              retry_req,
  output logic              irq_underflow,
  output logic              irq_tx,
  output logic              suspended
);
  import txstat_pkg::*;

  tx_state_e  state_q;
  tx_flags_t  flg_q;
  logic       crs_seen_q;
  logic       uf_path_q;
  logic       susp_q;
  logic       retry_q;
  logic       irq_q;

  logic       in_defer, in_xmit;
  logic       defer_expired, win_late;
  logic       coll_hit, coll_final;
  logic [3:0] coll_cnt;
  logic       no_carrier;

  assign in_defer   = (state_q == ST_DEFER);
  assign in_xmit    = (state_q == ST_XMIT);
  assign coll_hit   = in_xmit && col && !underflow && !win_late;
  assign no_carrier = !(crs_seen_q || crs);

  txstat_defer_timer #(.DEFER_LIMIT(DEFER_LIMIT)) u_defer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (!in_defer),
    .run     (in_defer),
    .tick    (tick),
    .enable  (cfg_defer_chk),
    .expired (defer_expired)
  );

  txstat_slot_window #(.SLOT_BITS(SLOT_BITS)) u_window (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!in_xmit),
    .run   (in_xmit),
    .tick  (tick),
    .late  (win_late)
  );

  txstat_coll_tracker #(.MAX_COLL(MAX_COLL)) u_coll (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (state_q == ST_IDLE),
    .hit       (coll_hit),
    .retry_off (cfg_retry_off),
    .final_hit (coll_final),
    .count     (coll_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      flg_q      <= '0;
      crs_seen_q <= 1'b0;
      uf_path_q  <= 1'b0;
      susp_q     <= 1'b0;
      retry_q    <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      retry_q <= 1'b0;
      irq_q   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (frame_start) begin
            flg_q   <= '0;
            state_q <= ST_DEFER;
          end
        end
        ST_DEFER: begin
          if (crs && !cfg_full_duplex) flg_q.db <= 1'b1;
          if (tx_start) begin
            crs_seen_q <= 1'b0;
            state_q    <= ST_XMIT;
          end else if (defer_expired) begin
            flg_q.ed <= 1'b1;
            state_q  <= ST_REPORT;
          end
        end
        ST_XMIT: begin
          if (crs) crs_seen_q <= 1'b1;
          if (underflow) begin
            flg_q.uf  <= 1'b1;
            flg_q.nc  <= no_carrier;
            susp_q    <= 1'b1;
            irq_q     <= 1'b1;
            uf_path_q <= 1'b1;
            state_q   <= ST_REPORT;
          end else if (col && win_late) begin
            flg_q.lc <= 1'b1;
            flg_q.nc <= no_carrier;
            state_q  <= ST_REPORT;
          end else if (coll_final) begin
            flg_q.ec <= 1'b1;
            flg_q.nc <= no_carrier;
            state_q  <= ST_REPORT;
          end else if (coll_hit) begin
            retry_q <= 1'b1;
            state_q <= ST_DEFER;
          end else if (tx_end) begin
            flg_q.nc <= no_carrier;
            state_q  <= ST_REPORT;
          end
        end
        ST_REPORT: begin
          if (stat_ready) begin
            state_q   <= uf_path_q ? ST_SUSP : ST_IDLE;
            uf_path_q <= 1'b0;
          end
        end
        ST_SUSP: begin
          if (resume) begin
            susp_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stat_word                  = '0;
    stat_word[BIT_NC]          = flg_q.nc;
    stat_word[BIT_LC]          = flg_q.lc && !flg_q.uf;
    stat_word[BIT_EC]          = flg_q.ec;
    stat_word[BIT_CC_LO +: 4]  = flg_q.ec ? 4'd0 : coll_cnt;
    stat_word[BIT_ED]          = flg_q.ed;
    stat_word[BIT_UF]          = flg_q.uf;
    stat_word[BIT_DB]          = flg_q.db && !cfg_full_duplex;
  end

  assign stat_valid    = (state_q == ST_REPORT);
  assign retry_req     = retry_q;
  assign irq_underflow = irq_q;
  assign irq_tx        = irq_q;
  assign suspended     = susp_q;

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && !stat_ready |=> stat_valid && $stable(stat_word)); // R12
  AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && stat_ready |=> !stat_valid); // R12
  AST_RETRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |=> !retry_req); // R1
  AST_CC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && stat_word[BIT_EC] |-> stat_word[BIT_CC_LO +: 4] == 4'd0); // R2
  AST_LC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && stat_word[BIT_UF] |-> !stat_word[BIT_LC]); // R5
  AST_UF_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_underflow |-> irq_tx && suspended && stat_valid); // R7
  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && !resume |=> suspended); // R8
  AST_NO_RETRY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_retry_off && $stable(cfg_retry_off) |-> !retry_req); // R3
endmodule

// File: tb/hdx_txstat_tracker_tb_top.sv
module hdx_txstat_tracker_tb_top;
  localparam int SLOT = 16;
  localparam int DLIM = 40;
  localparam int MAXC = 16;
  localparam int SW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_retry_off = 1'b0, cfg_defer_chk = 1'b0, cfg_full_duplex = 1'b0;
  logic frame_start = 1'b0, tx_start = 1'b0, tx_end = 1'b0, col = 1'b0;
  logic underflow = 1'b0, crs = 1'b0, tick = 1'b0, resume = 1'b0, stat_ready = 1'b0;
  logic stat_valid, retry_req, irq_underflow, irq_tx, suspended;
  logic [SW-1:0] stat_word;

  int n_chk = 0;
  int n_fail = 0;
  int retry_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hdx_txstat_tracker #(.SLOT_BITS(SLOT), .DEFER_LIMIT(DLIM), .MAX_COLL(MAXC), .STAT_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_retry_off(cfg_retry_off), .cfg_defer_chk(cfg_defer_chk),
    .cfg_full_duplex(cfg_full_duplex), .frame_start(frame_start), .tx_start(tx_start),
    .tx_end(tx_end), .col(col), .underflow(underflow), .crs(crs), .tick(tick),
    .resume(resume), .stat_ready(stat_ready), .stat_valid(stat_valid), .stat_word(stat_word),
    .retry_req(retry_req), .irq_underflow(irq_underflow), .irq_tx(irq_tx), .suspended(suspended)
  );

  always @(negedge clk) if (retry_req) retry_cnt++;

  function automatic logic [SW-1:0] mk(bit nc, bit lc, bit ec, int cc, bit ed, bit uf, bit db);
    logic [SW-1:0] w;
    w = '0;
    w = w | (SW'(nc) << 10) | (SW'(lc) << 9) | (SW'(ec) << 8) | (SW'(cc & 15) << 3);
    w = w | (SW'(ed) << 2) | (SW'(uf) << 1) | SW'(db);
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input int which);
    case (which)
      0: frame_start = 1'b1;
      1: tx_start = 1'b1;
      2: tx_end = 1'b1;
      default: resume = 1'b1;
    endcase
    @(negedge clk);
    frame_start = 1'b0; tx_start = 1'b0; tx_end = 1'b0; resume = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic collide();
    col = 1'b1; crs = 1'b0;
    @(negedge clk);
    col = 1'b0;
  endtask

  task automatic attempt(input int k);
    pulse(1);
    crs = 1'b1;
    ticks(k);
  endtask

  task automatic finish_ok();
    pulse(2);
    crs = 1'b0;
  endtask

  task automatic take_status(input logic [SW-1:0] exp, input string tag);
    int waited;
    waited = 0;
    while (!stat_valid && waited < 60) begin
      @(negedge clk);
      waited++;
    end
    chk(stat_valid == 1'b1, {tag, " valid"}, int'(stat_valid), 1);
    chk(stat_word == exp, tag, int'(stat_word), int'(exp));
    stat_ready = 1'b1;
    @(negedge clk);
    stat_ready = 1'b0;
    chk(stat_valid == 1'b0, "R12 valid drops after accept", int'(stat_valid), 0);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(!stat_valid && !retry_req && !irq_underflow && !irq_tx && !suspended,
        "R13 reset outputs", int'({stat_valid, retry_req, irq_underflow, irq_tx, suspended}), 0);

    // R1 / R2 collision count sweep
    for (int n = 0; n <= MAXC; n++) begin
      retry_cnt = 0;
      pulse(0);
      for (int a = 0; a < n; a++) begin
        attempt(2);
        collide();
      end
      if (n < MAXC) begin
        attempt(2);
        finish_ok();
        take_status(mk(0, 0, 0, n, 0, 0, 0), "R1 collision count");
        chk(retry_cnt == n, "R1 retry pulses", retry_cnt, n);
      end else begin
        take_status(mk(0, 0, 1, 0, 0, 0, 0), "R2 excessive collisions");
        chk(retry_cnt == MAXC - 1, "R2 retry pulses", retry_cnt, MAXC - 1);
      end
    end

    // R3 retry disabled
    cfg_retry_off = 1'b1;
    @(negedge clk);
    retry_cnt = 0;
    pulse(0);
    attempt(2);
    collide();
    take_status(mk(0, 0, 1, 0, 0, 0, 0), "R3 first collision aborts");
    chk(retry_cnt == 0, "R3 no retry", retry_cnt, 0);
    cfg_retry_off = 1'b0;
    @(negedge clk);

    // R4 late collision threshold and per-attempt window restart
    for (int k = SLOT - 4; k <= SLOT + 3; k++) begin
      retry_cnt = 0;
      pulse(0);
      attempt(k);
      collide();
      if (k >= SLOT) begin
        take_status(mk(0, 1, 0, 0, 0, 0, 0), "R4 late collision");
        chk(retry_cnt == 0, "R4 no retry on late", retry_cnt, 0);
      end else begin
        attempt(k);
        finish_ok();
        take_status(mk(0, 0, 0, 1, 0, 0, 0), "R4 in-window collision");
      end
    end

    // R6 deferral limit sweep
    cfg_defer_chk = 1'b1;
    for (int d = DLIM - 2; d <= DLIM + 2; d++) begin
      pulse(0);
      ticks(d);
      if (d > DLIM) begin
        take_status(mk(0, 0, 0, 0, 1, 0, 0), "R6 excessive deferral");
      end else begin
        attempt(2);
        finish_ok();
        take_status(mk(0, 0, 0, 0, 0, 0, 0), "R6 deferral within limit");
      end
    end
    pulse(0);
    ticks(DLIM - 5);
    attempt(2);
    collide();
    ticks(DLIM - 5);
    attempt(2);
    finish_ok();
    take_status(mk(0, 0, 0, 1, 0, 0, 0), "R6 timer restarts per attempt");
    cfg_defer_chk = 1'b0;
    pulse(0);
    ticks(DLIM + 20);
    attempt(2);
    finish_ok();
    take_status(mk(0, 0, 0, 0, 0, 0, 0), "R6 check disabled");

    // R9 no carrier
    pulse(0);
    pulse(1);
    ticks(3);
    finish_ok();
    take_status(mk(1, 0, 0, 0, 0, 0, 0), "R9 no carrier");

    // R10 deferred flag, half then full duplex
    for (int fd = 0; fd < 2; fd++) begin
      cfg_full_duplex = fd[0];
      pulse(0);
      crs = 1'b1;
      ticks(3);
      crs = 1'b0;
      attempt(2);
      finish_ok();
      take_status(mk(0, 0, 0, 0, 0, 0, (fd == 0)), "R10 deferred flag");
    end
    cfg_full_duplex = 1'b0;

    // R5 / R7 / R8 underflow with simultaneous late collision
    pulse(0);
    attempt(SLOT + 4);
    underflow = 1'b1; col = 1'b1; crs = 1'b0;
    @(negedge clk);
    underflow = 1'b0; col = 1'b0;
    chk(irq_underflow && irq_tx && suspended, "R7 underflow indications",
        int'({irq_underflow, irq_tx, suspended}), 7);
    @(negedge clk);
    chk(!irq_underflow && !irq_tx, "R7 irq one cycle", int'({irq_underflow, irq_tx}), 0);
    take_status(mk(0, 0, 0, 0, 0, 1, 0), "R5 underflow beats late collision");
    chk(suspended == 1'b1, "R7 suspended after report", int'(suspended), 1);
    pulse(0);
    attempt(2);
    finish_ok();
    repeat (3) @(negedge clk);
    chk(!stat_valid && suspended, "R8 frame ignored while suspended",
        int'({stat_valid, suspended}), 1);
    pulse(3);
    chk(suspended == 1'b0, "R8 resume clears", int'(suspended), 0);
    pulse(0);
    attempt(2);
    finish_ok();
    take_status(mk(0, 0, 0, 0, 0, 0, 0), "R11 flags cleared on new frame");

    // R12 back-pressure: word holds, events ignored
    pulse(0);
    attempt(2);
    collide();
    attempt(2);
    finish_ok();
    for (int c = 0; c < 4; c++) begin
      col = 1'b1; frame_start = 1'b1; underflow = 1'b1; crs = 1'b1;
      @(negedge clk);
      col = 1'b0; frame_start = 1'b0; underflow = 1'b0; crs = 1'b0;
      chk(stat_valid && stat_word == mk(0, 0, 0, 1, 0, 0, 0), "R12 word held",
          int'(stat_word), int'(mk(0, 0, 0, 1, 0, 0, 0)));
    end
    chk(suspended == 1'b0, "R12 underflow ignored while waiting", int'(suspended), 0);
    take_status(mk(0, 0, 0, 1, 0, 0, 0), "R12 accepted word");
    // R11 unused bits zero checked through every mk comparison above
    chk(stat_word[7] == 1'b0 && stat_word[SW-1:11] == '0, "R11 reserved bits",
        int'(stat_word), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule